// File: doc/BRIEF.md
# Configurable Interrupt Aggregation Controller

This block gathers a vector of condition signals from elsewhere in the chip and merges them into a single interrupt line for a host processor. Every source first passes through a two-flop synchronizer. It then has its own two-bit trigger setting: level, rising edge or falling edge. Edge-triggered sources latch a status bit that stays set until software reads the status register. Level-triggered sources show the synchronized input value directly in their status bit.

A per-source enable mask decides which status bits may drive the interrupt line. The line is driven through an output-enable and data pair, so the pad can run in one of three ways:
- active-high push-pull;
- active-low push-pull;
- active-low open-drain, which pulls low only while asserting and suits a wired-OR line shared by several devices.

Software reaches the four configuration and status registers through a simple single-cycle read/write port. Read data is combinational from the address. Side effects of a read take place at the clock edge that ends the read cycle.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset the mask reads 0, every trigger setting reads 00 (level), the drive mode reads 00 (active-high), status reads 0, and the pin outputs are `irq_oe_o`=1 and `irq_do_o`=0.
- R2: The register map is: address 0 mask (bit i enables source i), address 1 trigger settings (bits 2i+1:2i for source i), address 2 status (bit i for source i), and address 3 drive mode (bits 1:0). A written register reads back its value, and bits above the field width read as 0.
- R3: Trigger code 00 and the reserved code 11 are level. The status bit equals the input as sampled through the synchronizer. It becomes visible after the third rising clock edge following a change made between edges, and a status read does not clear it.
- R4: Trigger code 01 is rising edge. A 0-to-1 transition of the synchronized input sets the status bit, which then holds until a status read clears it at the edge that ends the read. A 1-to-0 transition sets nothing.
- R5: Trigger code 10 is falling edge. A 1-to-0 transition sets the status bit, and a 0-to-1 transition sets nothing.
- R6: When an edge event and a clearing status read fall on the same clock edge, the status bit ends up set.
- R7: The interrupt is asserted exactly when the status AND the mask is non-zero. A masked source still records status but cannot assert the line.
- R8: Drive mode 00 gives oe=1 and data equal to the asserted state. Mode 01 gives oe=1 and data equal to the inverted asserted state. Mode 10 gives data held at 0 and oe=1 only while asserted. Mode 11 behaves as mode 00.
- R9: An input pulse that rises and falls between two consecutive clock edges is never sampled and sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Raw condition inputs, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (status read clears edge bits) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 2*NUM_SRC | Write data |
| rdata_o | output | 2*NUM_SRC | Read data for `addr_i` |
| irq_oe_o | output | 1 | Interrupt pad output enable |
| irq_do_o | output | 1 | Interrupt pad data value |

## Verification
The bench measures synchronizer latency edge by edge. A design that dropped or added a stage would show the new level one read early or one read late. It lines up a status read with an edge event on the same clock edge; a design that gave the clear priority would lose that interrupt. It also checks that reads clear edge bits but leave level bits alone, and that falling edges do not set rising-mode bits. Finally it walks through every drive mode both with and without a pending interrupt, including the reserved codes, so a polarity slip or an open-drain stage that drives high shows up as a wrong pad value.

// File: rtl/irq_agg_pkg.sv
// Package: shared encodings for the interrupt aggregation controller.
// Assumes: two-bit fields for trigger setting and drive mode.
package irq_agg_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'b00,
        TRIG_RISE   = 2'b01,
        TRIG_FALL   = 2'b10,
        TRIG_LEVEL2 = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        DRV_HIGH   = 2'b00,
        DRV_LOW    = 2'b01,
        DRV_OPEN   = 2'b10,
        DRV_HIGH2  = 2'b11
    } drive_e;

    localparam logic [1:0] ADR_MASK = 2'd0;
    localparam logic [1:0] ADR_TRIG = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_MODE = 2'd3;

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; no cross-bit coherence is needed.
module irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Purpose: shift raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/irq_src_cell.sv
// Module: irq_src_cell
// One interrupt source: edge detection and status latch per trigger setting.
// Assumes: smp_i is already synchronized; clr_i is a one-cycle status read.
module irq_src_cell
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_i,
    input  logic [1:0] trig_i,
    input  logic       clr_i,
    output logic       stat_o,
    output logic       evt_o,
    output logic       lvl_o
);
    logic prev_q;
    logic stat_q;
    logic rise_w;
    logic fall_w;

    // Purpose: remember last synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise_w = smp_i & ~prev_q;
    assign fall_w = ~smp_i & prev_q;

    // Purpose: decode trigger setting into level flag and edge event.
    always_comb begin
        lvl_o = 1'b0;
        evt_o = 1'b0;
        case (trig_e'(trig_i))
            TRIG_RISE: evt_o = rise_w;
            TRIG_FALL: evt_o = fall_w;
            default:   lvl_o = 1'b1;
        endcase
    end

    // Purpose: status follows level or latches edges until read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (lvl_o) stat_q <= smp_i;
        else            stat_q <= evt_o | (stat_q & ~clr_i);
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_out_stage.sv
// Module: irq_out_stage
// Maps the pending flag to pad enable/data for the chosen drive mode.
// Assumes: pad logic outside resolves enable=0 as released.
module irq_out_stage
    import irq_agg_pkg::*;
(
    input  logic       pend_i,
    input  logic [1:0] mode_i,
    output logic       oe_o,
    output logic       do_o
);
    // Purpose: select polarity and drive style.
    always_comb begin
        case (drive_e'(mode_i))
            DRV_LOW: begin
                oe_o = 1'b1;
                do_o = ~pend_i;
            end
            DRV_OPEN: begin
                oe_o = pend_i;
                do_o = 1'b0;
            end
            default: begin
                oe_o = 1'b1;
                do_o = pend_i;
            end
        endcase
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
// Module: irq_agg_ctrl (top)
// Interrupt aggregation: synchronizer, per-source trigger cells, register
// file and pad stage. Read data is combinational; read side effects happen
// at the clock edge closing the read cycle.
// Assumes: NUM_SRC >= 1; wr_en_i and rd_en_i are not both set to one address.
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_i,
    input  logic                   wr_en_i,
    input  logic                   rd_en_i,
    input  logic [1:0]             addr_i,
    input  logic [2*NUM_SRC-1:0]   wdata_i,
    output logic [2*NUM_SRC-1:0]   rdata_o,
    output logic                   irq_oe_o,
    output logic                   irq_do_o
);
    localparam int DW = 2 * NUM_SRC;

    logic [NUM_SRC-1:0] mask_q;
    logic [DW-1:0]      trig_q;
    logic [1:0]         mode_q;
    logic [NUM_SRC-1:0] sync_v;
    logic [NUM_SRC-1:0] status_v;
    logic [NUM_SRC-1:0] evt_v;
    logic [NUM_SRC-1:0] lvl_v;
    logic               stat_rd;
    logic               pend_w;

    assign stat_rd = rd_en_i && (addr_i == ADR_STAT);

    // Purpose: configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            trig_q <= '0;
            mode_q <= 2'b00;
        end else if (wr_en_i) begin
            case (addr_i)
                ADR_MASK: mask_q <= wdata_i[NUM_SRC-1:0];
                ADR_TRIG: trig_q <= wdata_i;
                ADR_MODE: mode_q <= wdata_i[1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: read data multiplexer, zero-extended.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_MASK: rdata_o[NUM_SRC-1:0] = mask_q;
            ADR_TRIG: rdata_o = trig_q;
            ADR_STAT: rdata_o[NUM_SRC-1:0] = status_v;
            default:  rdata_o[1:0] = mode_q;
        endcase
    end

    irq_sync #(.WIDTH(NUM_SRC)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (sync_v)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irq_src_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (sync_v[g]),
            .trig_i (trig_q[2*g +: 2]),
            .clr_i  (stat_rd),
            .stat_o (status_v[g]),
            .evt_o  (evt_v[g]),
            .lvl_o  (lvl_v[g])
        );
    end

    assign pend_w = |(status_v & mask_q);

    irq_out_stage out_i (
        .pend_i (pend_w),
        .mode_i (mode_q),
        .oe_o   (irq_oe_o),
        .do_o   (irq_do_o)
    );
endmodule

// File: rtl/irq_agg_chk.sv
// Module: irq_agg_chk
// Property checker bound into irq_agg_ctrl.
// Assumes: connected to the top's internal status, event and level vectors.
module irq_agg_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_oe_o,
    input logic               irq_do_o,
    input logic [1:0]         mode_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] status_v,
    input logic [NUM_SRC-1:0] evt_v,
    input logic [NUM_SRC-1:0] lvl_v,
    input logic [NUM_SRC-1:0] sync_v,
    input logic               stat_rd
);
    // R3: level bits copy the synchronized sample taken at the previous edge.
    p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_v & $past(lvl_v)) == ($past(sync_v) & $past(lvl_v))));

    // R4: a status read leaves no edge bit set unless an event came with it.
    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((status_v & ~$past(lvl_v) & ~$past(evt_v)) == '0));

    // R6: an event always leaves its status bit set.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_v) |=> ((status_v & $past(evt_v)) == $past(evt_v)));

    // R7: nothing pending under the mask means the pad shows deasserted.
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_v & mask_q) == '0) |->
            ((mode_q == 2'b10) ? !irq_oe_o :
             (mode_q == 2'b01) ? (irq_oe_o && irq_do_o) :
                                 (irq_oe_o && !irq_do_o)));

    // R8: open-drain never drives a high value.
    p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10) |-> !irq_do_o);
endmodule

bind irq_agg_ctrl irq_agg_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_oe_o (irq_oe_o),
    .irq_do_o (irq_do_o),
    .mode_q   (mode_q),
    .mask_q   (mask_q),
    .status_v (status_v),
    .evt_v    (evt_v),
    .lvl_v    (lvl_v),
    .sync_v   (sync_v),
    .stat_rd  (stat_rd)
);

// File: tb/irq_agg_ctrl_tb_top.sv
// Directed bench for irq_agg_ctrl: one task per scenario.
module irq_agg_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   src = '0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [1:0]     addr = 2'd0;
    logic [2*N-1:0] wdata = '0;
    logic [2*N-1:0] rdata;
    logic           irq_oe;
    logic           irq_do;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_ctrl #(.NUM_SRC(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_oe_o (irq_oe),
        .irq_do_o (irq_do)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All access tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [2*N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [2*N-1:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [2*N-1:0] v;
        rd(2'd0, v); chk("R1 mask", v, 0);
        rd(2'd1, v); chk("R1 trig", v, 0);
        rd(2'd3, v); chk("R1 mode", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        chk("R1 oe", irq_oe, 1);
        chk("R1 do", irq_do, 0);
    endtask

    task automatic t_regs();
        logic [2*N-1:0] v;
        wr(2'd0, 16'hFFA5); rd(2'd0, v); chk("R2 mask upper bits zero", v, 16'h00A5);
        wr(2'd1, 16'h1234); rd(2'd1, v); chk("R2 trig readback", v, 16'h1234);
        wr(2'd3, 16'hFFFE); rd(2'd3, v); chk("R2 mode upper bits zero", v, 16'h0002);
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd3, 0);
    endtask

    task automatic t_level();
        logic [2*N-1:0] v;
        src = 8'h3C; settle();
        rd(2'd2, v); chk("R3 level status", v, 16'h003C);
        rd(2'd2, v); chk("R3 level not cleared", v, 16'h003C);
        src = 8'h81;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(2'd2, v); chk("R3 not visible after two edges", v, 16'h003C);
        rd(2'd2, v); chk("R3 visible after third edge", v, 16'h0081);
        wr(2'd1, 16'h0003); src = 8'h01; settle();
        rd(2'd2, v); chk("R3 reserved code as level", v, 16'h0001);
        rd(2'd2, v); chk("R3 reserved code not cleared", v, 16'h0001);
        src = 8'h00; settle();
        rd(2'd2, v); chk("R3 reserved code follows low", v, 16'h0000);
    endtask

    task automatic t_rise();
        logic [2*N-1:0] v;
        wr(2'd1, 16'h5555); src = 8'h00; settle(); rd(2'd2, v);
        src = 8'h0F; settle();
        rd(2'd2, v); chk("R4 rising latched", v, 16'h000F);
        rd(2'd2, v); chk("R4 cleared by read", v, 16'h0000);
        src = 8'h00; settle();
        rd(2'd2, v); chk("R4 falling ignored", v, 16'h0000);
    endtask

    task automatic t_fall();
        logic [2*N-1:0] v;
        wr(2'd1, 16'hAAAA); src = 8'hFF; settle();
        rd(2'd2, v); chk("R5 rising ignored", v, 16'h0000);
        src = 8'hF0; settle();
        rd(2'd2, v); chk("R5 falling latched", v, 16'h000F);
        rd(2'd2, v); chk("R5 cleared by read", v, 16'h0000);
        src = 8'h00; settle(); rd(2'd2, v);
    endtask

    task automatic t_set_wins();
        logic [2*N-1:0] v;
        wr(2'd1, 16'h5555); src = 8'h00; settle(); rd(2'd2, v);
        src = 8'h04;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(2'd2, v); chk("R6 read before event", v, 16'h0000);
        rd(2'd2, v); chk("R6 event survives same-edge clear", v, 16'h0004);
        src = 8'h00; settle(); rd(2'd2, v);
    endtask

    task automatic t_mask_modes();
        logic [2*N-1:0] v;
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0000); wr(2'd3, 16'h0000);
        src = 8'h10; settle();
        rd(2'd2, v); chk("R7 masked status recorded", v, 16'h0010);
        chk("R7 masked no assert", irq_do, 0);
        wr(2'd0, 16'h0010); chk("R7 unmasked asserts", irq_do, 1);
        wr(2'd0, 16'h00EF); chk("R7 other bits no assert", irq_do, 0);
        wr(2'd0, 16'h0010);
        wr(2'd3, 16'h0001); chk("R8 low asserted oe", irq_oe, 1); chk("R8 low asserted do", irq_do, 0);
        wr(2'd3, 16'h0002); chk("R8 od asserted oe", irq_oe, 1); chk("R8 od asserted do", irq_do, 0);
        wr(2'd3, 16'h0003); chk("R8 code3 asserted do", irq_do, 1);
        wr(2'd0, 16'h0000);
        chk("R8 code3 idle do", irq_do, 0);
        wr(2'd3, 16'h0002); chk("R8 od idle oe", irq_oe, 0); chk("R8 od idle do", irq_do, 0);
        wr(2'd3, 16'h0001); chk("R8 low idle oe", irq_oe, 1); chk("R8 low idle do", irq_do, 1);
        wr(2'd3, 16'h0000); src = 8'h00; settle();
    endtask

    task automatic t_glitch();
        logic [2*N-1:0] v;
        wr(2'd1, 16'h5555); src = 8'h00; settle(); rd(2'd2, v);
        @(posedge clk);
        #1 src = 8'h01;
        #3 src = 8'h00;
        @(negedge clk); settle();
        rd(2'd2, v); chk("R9 glitch sets nothing", v, 16'h0000);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_level();
        t_rise();
        t_fall();
        t_set_wins();
        t_mask_modes();
        t_glitch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule